// File: doc/BRIEF.md
# Decoded Register-Transfer Bus Datapath

This block is a small bank of general registers joined by one shared data bus. A short instruction word names a source register and a destination register. The source field goes through a binary-to-one-hot decoder that picks exactly one register to drive the bus. The bus is built as a one-hot-selected multiplexer, so no tristate drivers are needed. The destination field goes through a second decoder whose outputs are gated by a common transfer strobe. The chosen register captures the bus value on the clock edge where the strobe is high. The copy is plain: the destination receives the source contents bit for bit.

A separate set of per-register load ports lets the surrounding logic set initial contents. An initial load has priority over a bus transfer aimed at the same register. A synchronous reset clears every register. The register contents and the live bus value are both outputs, so a controller can see the effect of each move. The register width, the register count (a power of two) and the multiplexer style are parameters.

Top module: `regbus_move_dp`

## Requirements
- R1: When `rst` is high at a rising clock edge, every register is zero after that edge.
- R2: `bus_out` always equals the contents of the register whose index is in the source field `instr[SEL_W-1:0]` (bits [1:0] by default), in the same cycle with no clock delay.
- R3: With `xfer_stb` high at a rising edge, the register whose index is in the destination field `instr[2*SEL_W-1:SEL_W]` (bits [3:2] by default) holds, after that edge, the bus value from before the edge, without modification.
- R4: With `xfer_stb` low and no initial load, no register changes at a clock edge, whatever `instr` holds.
- R5: A transfer writes only the destination register. Every other register without an initial load keeps its value.
- R6: When the source and destination fields are equal and the strobe is high, that register keeps its contents.
- R7: When `init_we[i]` is high at a rising edge, register i takes slice i of `init_data` (bits [i*DATA_W +: DATA_W]). This holds even when a transfer targets the same register in that cycle.
- R8: The source decoder drives exactly one enable at all times, so exactly one register drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| instr | input | 2*SEL_W | Move instruction: low field source index, high field destination index |
| xfer_stb | input | 1 | Transfer strobe that gates the destination decoder |
| init_we | input | NUM_REGS | Per-register initial load enables |
| init_data | input | NUM_REGS*DATA_W | Initial load values, slice i for register i |
| regs_out | output | NUM_REGS*DATA_W | Register contents, slice i is register i |
| bus_out | output | DATA_W | Current shared bus value |

## Verification
On every cycle, the assertions check several properties. The source enable must be exactly one-hot, and the destination enable must be silent while the strobe is low. The bus must match the selected register. Each register must either hold, take its initial load, or take the bus value, as the enables dictate. Some behaviours only the bench's scenarios can show. These are reset clearing contents that were first made non-zero, a self-move keeping a known value, an initial load winning over a transfer into the same register, and long random runs of moves against a reference model.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

   // Implementation choice for the bus multiplexer.
   typedef enum logic {
      MUX_AND_OR   = 1'b0,  // one-hot AND-OR reduction
      MUX_INDEXED  = 1'b1   // one-hot to binary encode, then indexed select
   } mux_style_e;

   // True when n is a power of two and at least two.
   function automatic bit is_pow2_min2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/rb_onehot_dec.sv
module rb_onehot_dec #(
   parameter int SEL_W = 2,
   localparam int OUT_N = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             en,
   output logic [OUT_N-1:0] dec
);

   if (SEL_W < 1) begin : g_bad_width
      $error("rb_onehot_dec: SEL_W must be at least 1");
   end

   for (genvar i = 0; i < OUT_N; i++) begin : g_line
      assign dec[i] = en && (sel == SEL_W'(i));
   end

endmodule

// File: rtl/rb_bus_mux.sv
module rb_bus_mux #(
   parameter int                     DATA_W    = 8,
   parameter int                     NUM_SRC   = 4,
   parameter regbus_pkg::mux_style_e MUX_STYLE = regbus_pkg::MUX_AND_OR,
   localparam int                    IDX_W     = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]        onehot,
   input  logic [NUM_SRC*DATA_W-1:0] data,
   output logic [DATA_W-1:0]         y
);

   if (MUX_STYLE == regbus_pkg::MUX_AND_OR) begin : g_and_or
      always_comb begin
         y = '0;
         for (int i = 0; i < NUM_SRC; i++) begin
            y = y | (data[i*DATA_W +: DATA_W] & {DATA_W{onehot[i]}});
         end
      end
   end else begin : g_indexed
      logic [IDX_W-1:0] idx;
      always_comb begin
         idx = '0;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (onehot[i]) idx = idx | IDX_W'(i);
         end
      end
      assign y = data[idx*DATA_W +: DATA_W];
   end

endmodule

// File: rtl/rb_regbank.sv
module rb_regbank #(
   parameter int DATA_W = 8,
   parameter int NUM_REGS = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_REGS-1:0]        ld_en,
   input  logic [DATA_W-1:0]          bus,
   input  logic [NUM_REGS-1:0]        init_we,
   input  logic [NUM_REGS*DATA_W-1:0] init_data,
   output logic [NUM_REGS*DATA_W-1:0] regs_q
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst) begin
            q <= '0;
         end else if (init_we[i]) begin
            q <= init_data[i*DATA_W +: DATA_W];
         end else if (ld_en[i]) begin
            q <= bus;
         end
      end
      assign regs_q[i*DATA_W +: DATA_W] = q;
   end

endmodule

// File: rtl/regbus_move_dp.sv
module regbus_move_dp #(
   parameter int                     DATA_W    = 8,
   parameter int                     NUM_REGS  = 4,
   parameter regbus_pkg::mux_style_e MUX_STYLE = regbus_pkg::MUX_AND_OR,
   localparam int                    SEL_W     = $clog2(NUM_REGS),
   localparam int                    INSTR_W   = 2 * SEL_W
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [INSTR_W-1:0]         instr,
   input  logic                       xfer_stb,
   input  logic [NUM_REGS-1:0]        init_we,
   input  logic [NUM_REGS*DATA_W-1:0] init_data,
   output logic [NUM_REGS*DATA_W-1:0] regs_out,
   output logic [DATA_W-1:0]          bus_out
);

   if (!regbus_pkg::is_pow2_min2(NUM_REGS)) begin : g_bad_count
      $error("regbus_move_dp: NUM_REGS must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("regbus_move_dp: DATA_W must be at least 1");
   end

   logic [SEL_W-1:0]           src_sel;
   logic [SEL_W-1:0]           dst_sel;
   logic [NUM_REGS-1:0]        src_en;
   logic [NUM_REGS-1:0]        ld_en;
   logic [DATA_W-1:0]          bus;
   logic [NUM_REGS*DATA_W-1:0] regs_q;

   assign src_sel = instr[SEL_W-1:0];
   assign dst_sel = instr[INSTR_W-1:SEL_W];

   // Source side: always enabled, exactly one driver on the bus.
   rb_onehot_dec #(.SEL_W(SEL_W)) u_src_dec (
      .sel (src_sel),
      .en  (1'b1),
      .dec (src_en)
   );

   // Destination side: gated by the transfer strobe.
   rb_onehot_dec #(.SEL_W(SEL_W)) u_dst_dec (
      .sel (dst_sel),
      .en  (xfer_stb),
      .dec (ld_en)
   );

   rb_bus_mux #(
      .DATA_W    (DATA_W),
      .NUM_SRC   (NUM_REGS),
      .MUX_STYLE (MUX_STYLE)
   ) u_bus_mux (
      .onehot (src_en),
      .data   (regs_q),
      .y      (bus)
   );

   rb_regbank #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .ld_en     (ld_en),
      .bus       (bus),
      .init_we   (init_we),
      .init_data (init_data),
      .regs_q    (regs_q)
   );

   assign regs_out = regs_q;
   assign bus_out  = bus;

endmodule

// File: rtl/regbus_move_dp_chk.sv
module regbus_move_dp_chk #(
   parameter int  DATA_W   = 8,
   parameter int  NUM_REGS = 4,
   localparam int SEL_W    = $clog2(NUM_REGS),
   localparam int INSTR_W  = 2 * SEL_W
) (
   input logic                       clk,
   input logic                       rst,
   input logic [INSTR_W-1:0]         instr,
   input logic                       xfer_stb,
   input logic [NUM_REGS-1:0]        init_we,
   input logic [NUM_REGS*DATA_W-1:0] init_data,
   input logic [NUM_REGS*DATA_W-1:0] regs_out,
   input logic [DATA_W-1:0]          bus_out,
   input logic [NUM_REGS-1:0]        src_en,
   input logic [NUM_REGS-1:0]        ld_en
);

   logic [SEL_W-1:0] src_f;
   logic [SEL_W-1:0] dst_f;
   assign src_f = instr[SEL_W-1:0];
   assign dst_f = instr[INSTR_W-1:SEL_W];

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (regs_out == '0)); // R1

   AST_BUS_MATCH_SRC: assert property (@(posedge clk) disable iff (rst)
      bus_out == regs_out[src_f*DATA_W +: DATA_W]); // R2

   AST_SRC_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
      $countones(src_en) == 1); // R8

   AST_NO_LOAD_WITHOUT_STB: assert property (@(posedge clk) disable iff (rst)
      !xfer_stb |-> (ld_en == '0)); // R4

   AST_COPY_TO_DEST: assert property (@(posedge clk) disable iff (rst)
      (xfer_stb && !init_we[dst_f]) |=>
         regs_out[$past(dst_f)*DATA_W +: DATA_W] == $past(bus_out)); // R3

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_per_reg
      AST_HOLD_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
         (!init_we[i] && !(xfer_stb && dst_f == SEL_W'(i))) |=>
            $stable(regs_out[i*DATA_W +: DATA_W])); // R5

      AST_INIT_WINS: assert property (@(posedge clk) disable iff (rst)
         init_we[i] |=>
            regs_out[i*DATA_W +: DATA_W] == $past(init_data[i*DATA_W +: DATA_W])); // R7
   end

endmodule

bind regbus_move_dp regbus_move_dp_chk #(
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .instr     (instr),
   .xfer_stb  (xfer_stb),
   .init_we   (init_we),
   .init_data (init_data),
   .regs_out  (regs_out),
   .bus_out   (bus_out),
   .src_en    (src_en),
   .ld_en     (ld_en)
);

// File: tb/regbus_move_dp_tb.sv
module regbus_move_dp_tb;

   localparam int DW = 8;
   localparam int NR = 4;
   localparam int SW = 2;

   logic              clk = 1'b0;
   logic              rst;
   logic [2*SW-1:0]   instr;
   logic              xfer_stb;
   logic [NR-1:0]     init_we;
   logic [NR*DW-1:0]  init_data;
   logic [NR*DW-1:0]  regs_out;
   logic [DW-1:0]     bus_out;

   int tests  = 0;
   int fails  = 0;
   logic [DW-1:0] model [NR];

   always #5 clk = ~clk;

   regbus_move_dp #(.DATA_W(DW), .NUM_REGS(NR)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .instr     (instr),
      .xfer_stb  (xfer_stb),
      .init_we   (init_we),
      .init_data (init_data),
      .regs_out  (regs_out),
      .bus_out   (bus_out)
   );

   function automatic logic [DW-1:0] next_val(input int i, input logic [DW-1:0] cur,
                                              input logic [DW-1:0] bus_v);
      if (init_we[i])                               return init_data[i*DW +: DW];
      if (xfer_stb && instr[2*SW-1:SW] == SW'(i))   return bus_v;
      return cur;
   endfunction

   task automatic check_regs(input string tag);
      for (int i = 0; i < NR; i++) begin
         tests++;
         if (regs_out[i*DW +: DW] !== model[i]) begin
            fails++;
            $display("FAIL %s reg%0d actual=%h expected=%h", tag, i, regs_out[i*DW +: DW], model[i]);
         end
      end
   endtask

   // Drives one cycle at negedge, checks the bus, then checks registers after the edge.
   task automatic cycle(input logic [2*SW-1:0] ins, input logic stb,
                        input logic [NR-1:0] we, input logic [NR*DW-1:0] dat, input string tag);
      logic [DW-1:0] exp_bus;
      instr = ins; xfer_stb = stb; init_we = we; init_data = dat;
      #1;
      exp_bus = model[ins[SW-1:0]];
      tests++;
      if (bus_out !== exp_bus) begin
         fails++;
         $display("FAIL R2 %s bus actual=%h expected=%h", tag, bus_out, exp_bus);
      end
      for (int i = 0; i < NR; i++) model[i] = next_val(i, model[i], exp_bus);
      @(negedge clk);
      check_regs(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; xfer_stb = 1'b0; init_we = '0;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < NR; i++) model[i] = '0;
      check_regs("R1 reset");
   endtask

   initial begin
      rst = 1'b1; instr = '0; xfer_stb = 1'b0; init_we = '0; init_data = '0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < NR; i++) model[i] = '0;
      check_regs("R1 reset");

      // R7 initial load of distinct values
      cycle(4'b0000, 1'b0, 4'b1111, {8'hD4, 8'hC3, 8'hB2, 8'hA1}, "R7 init");
      // R8 / R2 each source alone on the bus
      for (int s = 0; s < NR; s++) cycle(4'(s), 1'b0, '0, '0, "R8 source select");
      // R4 no strobe: no change
      cycle(4'b1001, 1'b0, '0, '0, "R4 no strobe");
      // R3 / R5 move reg1 -> reg2
      cycle(4'b1001, 1'b1, '0, '0, "R3 R5 move 1to2");
      // R3 move reg3 -> reg0
      cycle(4'b0011, 1'b1, '0, '0, "R3 move 3to0");
      // R6 self move on reg3
      cycle(4'b1111, 1'b1, '0, '0, "R6 self move");
      // R7 init beats transfer into same register
      cycle(4'b0100, 1'b1, 4'b0010, {8'h00, 8'h00, 8'h5E, 8'h00}, "R7 init priority");
      // R1 reset after non-zero contents
      do_reset();

      void'($urandom(32'd20240611));
      cycle(4'b0000, 1'b0, 4'b1111, {8'h11, 8'h22, 8'h33, 8'h44}, "R7 reinit");
      for (int n = 0; n < 400; n++) begin
         logic [NR*DW-1:0] d;
         logic [NR-1:0]    w;
         d = {$urandom, $urandom} ;
         w = ($urandom % 5 == 0) ? NR'($urandom) : '0;
         cycle(4'($urandom), 1'($urandom), w, d, "R3 R5 random");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule